// File: doc/BRIEF.md
# Compare-output timer with two waveform channels

An 8-bit counter advances on a count-enable tick and drives two compare channels, A and B. Each channel holds a compare value and an output bit. On a compare match, or at the ends of the count, it sets, clears or toggles that bit. The action a channel takes depends on three things: its 2-bit action field, the 3-bit waveform mode and, in phase-correct operation, the direction in which the counter is stepping. The block also reports whether each channel has taken over its pin, and whether that pin's driver should be enabled for the given direction bit.

Configuration is written in a single strobe that loads the waveform mode and both action fields together. Compare values are written with one strobe per channel. In the PWM modes, compare writes are double-buffered so that a period is never cut short. The counter and the output bits are registered, and all state changes on the rising clock edge.

Top module: `tmr_cmp_wave`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cnt_o`, `wave_o`, `pin_take_o` and `pin_drv_o` are all zero. Reset also selects normal mode with both action fields set to 00 and both compare values set to 0.
- R2: In normal mode (`cfg_wave[1:0]`=00) each tick adds one to the count, wrapping from 255 to 0. A cycle with no tick changes neither the count nor `wave_o`.
- R3: In clear-on-match mode (`cfg_wave[1:0]`=10) a tick taken while the count equals the channel-A compare value returns the count to 0.
- R4: In fast PWM (`cfg_wave[1:0]`=11) the count runs from 0 up to TOP and then returns to 0. TOP is 255 when `cfg_wave[2]`=0 and is the channel-A compare value when `cfg_wave[2]`=1. Clear-on-match mode always uses the channel-A value as TOP.
- R5: In phase-correct PWM (`cfg_wave[1:0]`=01) the count rises from 0 to TOP and then falls back to 0. Each end value is held for only one tick before the direction reverses. TOP is chosen as in R4.
- R6: In normal and clear-on-match modes, a tick taken while the count equals the channel's compare value applies the channel's action field: 01 toggles the output, 10 clears it and 11 sets it. Action 00 leaves the output unchanged.
- R7: In fast PWM, action 10 clears the output on a match and sets it on the tick that wraps the count to 0. Action 11 does the reverse: it sets on a match and clears on the wrap.
- R8: In phase-correct PWM, action 10 clears the output on a match taken while stepping up and sets it on a match taken while stepping down. Action 11 does the reverse.
- R9: In either PWM mode, when the compare value equals TOP and the action is 10 or 11, the match has no effect. Fast PWM still applies the wrap action. Phase-correct PWM applies the set (action 10) or the clear (action 11) on the tick at TOP.
- R10: In the PWM modes, action 01 toggles the output on a match only for channel A and only when `cfg_wave[2]`=1. In every other PWM case action 01 leaves the output unchanged and the pin is not taken.
- R11: `pin_take_o[i]` is 1 exactly when channel i has a connected action: one that is not 00 and is not excluded by R10. It changes only after a configuration write. `pin_drv_o[i]` is `pin_take_o[i]` AND `dir_en[i]`.
- R12: In the PWM modes a compare write is held and takes effect on the tick that reaches TOP, at the point where the count turns. In normal and clear-on-match modes a compare write takes effect on the next cycle.
- R13: A configuration write returns the count to 0, sets the direction to up and loads any held compare values. The tick in the same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for this cycle |
| cfg_we | input | 1 | Load the waveform mode and both action fields |
| cfg_wave | input | 3 | Bits 1:0: 00 normal, 01 phase-correct, 10 clear-on-match, 11 fast. Bit 2: TOP from the channel-A compare value in the PWM modes |
| cfg_act_a | input | 2 | Channel A action field |
| cfg_act_b | input | 2 | Channel B action field |
| cmp_we | input | 2 | Compare write strobes; bit 0 is channel A |
| cmp_wdata | input | 8 | Compare write value |
| dir_en | input | 2 | Per-channel pin direction bit; 1 means output |
| cnt_o | output | 8 | Current count |
| wave_o | output | 2 | Channel output bits; bit 0 is channel A |
| pin_take_o | output | 2 | Channel has taken over its pin |
| pin_drv_o | output | 2 | Pin driver enable |

## Verification
A wrong count or a wrong direction shows up on `cnt_o` at the next tick. A missed or misplaced wrap shows up within one period. A wrong action decision shows up on `wave_o` on the same edge as the match or the turn that caused it. A fault in the compare buffer is quieter: it only shows when the count next reaches TOP. For that reason the directed runs write a new TOP in the middle of a period and check the period length on both sides of the change. The compare values 0, 254 and 255 are used often, so the cases where the compare value equals TOP, or lies at the end of the count, come up in every mode.

// File: rtl/tmr_cmp_pkg.sv
package tmr_cmp_pkg;

    typedef enum logic [1:0] {
        WF_NORMAL = 2'b00,
        WF_PHASE  = 2'b01,
        WF_CLEAR  = 2'b10,
        WF_FAST   = 2'b11
    } wave_kind_e;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } pin_act_e;

    typedef enum logic [1:0] {
        EV_HOLD,
        EV_SET,
        EV_CLEAR,
        EV_FLIP
    } pin_ev_e;

    typedef struct packed {
        logic       top_sel;
        wave_kind_e kind;
    } wave_cfg_t;

    // Both PWM encodings carry bit 0 set.
    function automatic logic is_pwm(wave_kind_e k);
        return k[0];
    endfunction

    function automatic logic chan_connected(wave_cfg_t c, pin_act_e a, logic is_a);
        logic ok;
        ok = (a != ACT_OFF);
        if (a == ACT_TOGGLE && is_pwm(c.kind))
            ok = is_a && c.top_sel;
        return ok;
    endfunction

    // Decide what happens to a channel output on this edge.
    function automatic pin_ev_e pick_event(wave_cfg_t c, pin_act_e a, logic is_a,
                                           logic hit, logic top_evt, logic step_up,
                                           logic cmp_is_top);
        pin_ev_e ev;
        ev = EV_HOLD;
        if (chan_connected(c, a, is_a)) begin
            if (a == ACT_TOGGLE) begin
                if (hit) ev = EV_FLIP;
            end else begin
                case (c.kind)
                    WF_FAST: begin
                        if (hit && !cmp_is_top)
                            ev = (a == ACT_CLEAR) ? EV_CLEAR : EV_SET;
                        if (top_evt)
                            ev = (a == ACT_CLEAR) ? EV_SET : EV_CLEAR;
                    end
                    WF_PHASE: begin
                        if (hit && !cmp_is_top)
                            ev = ((a == ACT_CLEAR) == step_up) ? EV_CLEAR : EV_SET;
                        if (top_evt && cmp_is_top)
                            ev = (a == ACT_CLEAR) ? EV_SET : EV_CLEAR;
                    end
                    default: begin
                        if (hit)
                            ev = (a == ACT_CLEAR) ? EV_CLEAR : EV_SET;
                    end
                endcase
            end
        end
        return ev;
    endfunction

endpackage

// File: rtl/tmr_cmp_counter.sv
module tmr_cmp_counter
    import tmr_cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         tick,
    input  wave_kind_e   kind,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         top_evt,
    output logic         step_up
);
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic         up_q, up_d;
    logic [W-1:0] cnt_d;
    logic         at_top;

    always_comb begin
        at_top  = (cnt == top);
        step_up = 1'b1;
        if (kind == WF_PHASE)
            step_up = up_q ? !at_top : (cnt == ZERO);
        top_evt = tick && at_top && (kind != WF_PHASE || up_q);

        cnt_d = cnt;
        up_d  = up_q;
        if (restart) begin
            cnt_d = ZERO;
            up_d  = 1'b1;
        end else if (tick) begin
            if (kind == WF_PHASE) begin
                if (top == ZERO)
                    cnt_d = ZERO;
                else if (step_up)
                    cnt_d = cnt + ONE;
                else
                    cnt_d = cnt - ONE;
                if (up_q && at_top)
                    up_d = 1'b0;
                else if (!up_q && cnt == ZERO)
                    up_d = 1'b1;
            end else begin
                // Normal mode has TOP at all-ones, so the wrap is the same rule.
                cnt_d = at_top ? ZERO : cnt + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= ZERO;
            up_q <= 1'b1;
        end else begin
            cnt  <= cnt_d;
            up_q <= up_d;
        end
    end

endmodule

// File: rtl/tmr_cmp_slot.sv
module tmr_cmp_slot #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         pwm,
    input  logic         load,
    output logic [W-1:0] live
);
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            live   <= '0;
        end else begin
            if (wr)
                hold_q <= wdata;
            if (restart)
                live <= hold_q;
            else if (wr && !pwm)
                live <= wdata;
            else if (load && pwm)
                live <= hold_q;
        end
    end

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
    import tmr_cmp_pkg::*;
#(
    parameter int W    = 8,
    parameter bit IS_A = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  wave_cfg_t    cfg,
    input  pin_act_e     act,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] live,
    input  logic [W-1:0] top,
    input  logic         top_evt,
    input  logic         step_up,
    input  logic         dir_en,
    output logic         wave,
    output logic         take,
    output logic         drv
);
    pin_ev_e ev;

    always_comb begin
        ev   = pick_event(cfg, act, IS_A, tick && (cnt == live), top_evt, step_up, live == top);
        take = chan_connected(cfg, act, IS_A);
        drv  = take && dir_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave <= 1'b0;
        end else begin
            case (ev)
                EV_SET:   wave <= 1'b1;
                EV_CLEAR: wave <= 1'b0;
                EV_FLIP:  wave <= !wave;
                default:  wave <= wave;
            endcase
        end
    end

endmodule

// File: rtl/tmr_cmp_wave.sv
module tmr_cmp_wave
    import tmr_cmp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_wave,
    input  logic [1:0]   cfg_act_a,
    input  logic [1:0]   cfg_act_b,
    input  logic [1:0]   cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic [1:0]   dir_en,
    output logic [W-1:0] cnt_o,
    output logic [1:0]   wave_o,
    output logic [1:0]   pin_take_o,
    output logic [1:0]   pin_drv_o
);
    localparam int CH = 2;

    wave_cfg_t          cfg_q;
    pin_act_e           act_q [CH];
    logic               eff_tick;
    logic [W-1:0]       top_val;
    logic               top_evt;
    logic               step_up;
    logic [CH-1:0][W-1:0] live;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.top_sel <= 1'b0;
            cfg_q.kind    <= WF_NORMAL;
            act_q[0]      <= ACT_OFF;
            act_q[1]      <= ACT_OFF;
        end else if (cfg_we) begin
            cfg_q.top_sel <= cfg_wave[2];
            cfg_q.kind    <= wave_kind_e'(cfg_wave[1:0]);
            act_q[0]      <= pin_act_e'(cfg_act_a);
            act_q[1]      <= pin_act_e'(cfg_act_b);
        end
    end

    always_comb begin
        eff_tick = tick && !cfg_we;
        if (cfg_q.kind == WF_CLEAR || (is_pwm(cfg_q.kind) && cfg_q.top_sel))
            top_val = live[0];
        else
            top_val = {W{1'b1}};
    end

    tmr_cmp_counter #(.W(W)) counter_i (
        .clk     (clk),
        .rst     (rst),
        .restart (cfg_we),
        .tick    (eff_tick),
        .kind    (cfg_q.kind),
        .top     (top_val),
        .cnt     (cnt_o),
        .top_evt (top_evt),
        .step_up (step_up)
    );

    for (genvar g = 0; g < CH; g++) begin : g_ch
        tmr_cmp_slot #(.W(W)) slot_i (
            .clk     (clk),
            .rst     (rst),
            .restart (cfg_we),
            .wr      (cmp_we[g]),
            .wdata   (cmp_wdata),
            .pwm     (is_pwm(cfg_q.kind)),
            .load    (top_evt),
            .live    (live[g])
        );

        tmr_cmp_chan #(.W(W), .IS_A(g == 0)) chan_i (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg_q),
            .act     (act_q[g]),
            .tick    (eff_tick),
            .cnt     (cnt_o),
            .live    (live[g]),
            .top     (top_val),
            .top_evt (top_evt),
            .step_up (step_up),
            .dir_en  (dir_en[g]),
            .wave    (wave_o[g]),
            .take    (pin_take_o[g]),
            .drv     (pin_drv_o[g])
        );
    end

endmodule

// File: rtl/tmr_cmp_wave_chk.sv
module tmr_cmp_wave_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         cfg_we,
    input logic [1:0]   kind,
    input logic [W-1:0] top,
    input logic [W-1:0] live_a,
    input logic [W-1:0] cnt,
    input logic [1:0]   wave,
    input logic [1:0]   take
);
    a_r2_normal_step: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b00 && tick && !cfg_we) |=> (cnt == $past(cnt) + 1'b1));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cfg_we) |=> ($stable(cnt) && $stable(wave)));

    a_r3_ctc_clear: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b10 && tick && !cfg_we && cnt == live_a) |=> (cnt == '0));

    a_r4_fast_wrap: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b11 && tick && !cfg_we && cnt == top) |=> (cnt == '0));

    a_r5_phase_moves: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'b01 && tick && !cfg_we && top != '0) |=> (cnt != $past(cnt)));

    a_r11_take_stable: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(take));

    a_r13_restart_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cnt == '0));

endmodule

bind tmr_cmp_wave tmr_cmp_wave_chk #(.W(W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .cfg_we (cfg_we),
    .kind   (cfg_q.kind),
    .top    (top_val),
    .live_a (live[0]),
    .cnt    (cnt_o),
    .wave   (wave_o),
    .take   (pin_take_o)
);

// File: tb/tmr_cmp_wave_tb_top.sv
`timescale 1ns/1ps
module tmr_cmp_wave_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_wave = '0;
    logic [1:0] cfg_act_a = '0;
    logic [1:0] cfg_act_b = '0;
    logic [1:0] cmp_we = '0;
    logic [7:0] cmp_wdata = '0;
    logic [1:0] dir_en = '0;
    logic [7:0] cnt_o;
    logic [1:0] wave_o, pin_take_o, pin_drv_o;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_cnt, m_up, m_kind, m_tsel;
    int m_act[2], m_hold[2], m_live[2], m_wave[2];

    always #2.5 clk = ~clk;

    tmr_cmp_wave dut_i (
        .clk(clk), .rst(rst), .tick(tick), .cfg_we(cfg_we), .cfg_wave(cfg_wave),
        .cfg_act_a(cfg_act_a), .cfg_act_b(cfg_act_b), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .dir_en(dir_en), .cnt_o(cnt_o), .wave_o(wave_o),
        .pin_take_o(pin_take_o), .pin_drv_o(pin_drv_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int m_pwm();
        return (m_kind == 1 || m_kind == 3) ? 1 : 0;
    endfunction

    function automatic int m_top();
        return (m_kind == 2 || (m_pwm() != 0 && m_tsel != 0)) ? m_live[0] : 255;
    endfunction

    function automatic int m_conn(int ch);
        if (m_act[ch] == 0) return 0;
        if (m_pwm() != 0 && m_act[ch] == 1) return (ch == 0 && m_tsel != 0) ? 1 : 0;
        return 1;
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_up = 1; m_kind = 0; m_tsel = 0;
        for (int c = 0; c < 2; c++) begin
            m_act[c] = 0; m_hold[c] = 0; m_live[c] = 0; m_wave[c] = 0;
        end
    endtask

    task automatic model_step();
        int top, eff, atop, su, tev, nxt, hit, istop, old;
        top  = m_top();
        eff  = (tick && !cfg_we) ? 1 : 0;
        atop = (m_cnt == top) ? 1 : 0;
        su   = 1;
        if (m_kind == 1) su = (m_up != 0) ? !atop : (m_cnt == 0);
        tev  = (eff != 0 && atop != 0 && (m_kind != 1 || m_up != 0)) ? 1 : 0;
        for (int c = 0; c < 2; c++) begin
            if (m_conn(c) != 0) begin
                hit   = (eff != 0 && m_cnt == m_live[c]) ? 1 : 0;
                istop = (m_live[c] == top) ? 1 : 0;
                if (m_act[c] == 1) begin
                    if (hit != 0) m_wave[c] = 1 - m_wave[c];
                end else if (m_kind == 3) begin
                    if (hit != 0 && istop == 0) m_wave[c] = (m_act[c] == 3) ? 1 : 0;
                    if (tev != 0) m_wave[c] = (m_act[c] == 2) ? 1 : 0;
                end else if (m_kind == 1) begin
                    if (hit != 0 && istop == 0) m_wave[c] = (m_act[c] == 2) ? (su == 0) : su;
                    if (tev != 0 && istop != 0) m_wave[c] = (m_act[c] == 2) ? 1 : 0;
                end else if (hit != 0) begin
                    m_wave[c] = (m_act[c] == 3) ? 1 : 0;
                end
            end
        end
        if (cfg_we) begin
            m_cnt = 0; m_up = 1;
        end else if (eff != 0) begin
            if (m_kind == 1) begin
                nxt = (top == 0) ? 0 : ((su != 0) ? m_cnt + 1 : m_cnt - 1);
                if (m_up != 0 && atop != 0) m_up = 0;
                else if (m_up == 0 && m_cnt == 0) m_up = 1;
                m_cnt = nxt;
            end else begin
                m_cnt = (atop != 0) ? 0 : (m_cnt + 1) % 256;
            end
        end
        for (int c = 0; c < 2; c++) begin
            old = m_hold[c];
            if (cmp_we[c]) m_hold[c] = cmp_wdata;
            if (cfg_we) m_live[c] = old;
            else if (cmp_we[c] && m_pwm() == 0) m_live[c] = cmp_wdata;
            else if (tev != 0 && m_pwm() != 0) m_live[c] = old;
        end
        if (cfg_we) begin
            m_kind = cfg_wave[1:0]; m_tsel = cfg_wave[2];
            m_act[0] = cfg_act_a; m_act[1] = cfg_act_b;
        end
    endtask

    function automatic string cnt_tag();
        case (m_kind)
            0: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic string wave_tag(int c);
        if (m_pwm() != 0 && m_act[c] == 1) return "R10";
        if (m_pwm() != 0 && m_act[c] >= 2 && m_live[c] == m_top()) return "R9";
        if (m_kind == 3) return "R7";
        if (m_kind == 1) return "R8";
        return "R6";
    endfunction

    task automatic compare_all();
        int tk, dv;
        tk = m_conn(0) + 2 * m_conn(1);
        dv = tk & int'(dir_en);
        chk(cnt_tag(), cnt_o, m_cnt);
        chk(wave_tag(0), wave_o[0], m_wave[0]);
        chk(wave_tag(1), wave_o[1], m_wave[1]);
        chk("R11", pin_take_o, tk);
        chk("R11", pin_drv_o, dv);
    endtask

    // one clock: inputs already set, called at a falling edge
    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        cfg_we = 1'b0;
        cmp_we = '0;
        tick   = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            cyc();
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr_cmp(input int c, input int v);
        cmp_we = (c == 0) ? 2'b01 : 2'b10;
        cmp_wdata = 8'(v);
        cyc();
    endtask

    task automatic wr_cfg(input int wv, input int aa, input int ab);
        cfg_we = 1'b1; cfg_wave = 3'(wv); cfg_act_a = 2'(aa); cfg_act_b = 2'(ab);
        cyc();
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int wv_list[8] = '{0, 2, 3, 7, 1, 5, 3, 1};
        int v;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", cnt_o, 0);
        chk("R1", wave_o, 0);
        chk("R1", pin_take_o, 0);
        chk("R1", pin_drv_o, 0);
        rst = 1'b0;
        dir_en = 2'b01;

        // R2: counting and holding
        ticks(3);
        chk("R2", cnt_o, 3);
        idle(2);
        chk("R2", cnt_o, 3);

        // R6 / R13 / R11: non-PWM actions
        wr_cmp(0, 2);
        wr_cmp(1, 1);
        wr_cfg(0, 1, 3);
        chk("R13", cnt_o, 0);
        ticks(3);
        chk("R6", wave_o, 3);
        chk("R11", pin_take_o, 3);
        chk("R11", pin_drv_o, 1);

        // R12 / R4: buffered TOP in fast PWM
        wr_cmp(0, 9);
        wr_cfg(7, 0, 0);
        wr_cmp(0, 3);
        ticks(5);
        chk("R12", cnt_o, 5);
        ticks(5);
        chk("R4", cnt_o, 0);
        ticks(3);
        chk("R12", cnt_o, 3);
        ticks(1);
        chk("R12", cnt_o, 0);

        // R10: toggle action in PWM
        wr_cfg(3, 1, 1);
        chk("R10", pin_take_o, 0);
        wr_cfg(7, 1, 1);
        chk("R10", pin_take_o, 1);

        // R9: compare equal to TOP in fast PWM
        wr_cmp(1, 255);
        wr_cfg(3, 0, 2);
        ticks(256);
        chk("R9", wave_o[1], 1);
        ticks(255);
        chk("R9", cnt_o, 255);
        ticks(1);
        chk("R9", wave_o[1], 1);

        // R8: direction dependent clear
        wr_cmp(1, 4);
        wr_cfg(1, 0, 2);
        ticks(5);
        chk("R8", cnt_o, 5);
        chk("R8", wave_o[1], 0);

        // R3: clear-on-match period
        wr_cmp(0, 5);
        wr_cfg(2, 0, 0);
        ticks(6);
        chk("R3", cnt_o, 0);

        // R5: up/down with small TOP
        wr_cmp(0, 3);
        wr_cfg(5, 0, 0);
        ticks(4);
        chk("R5", cnt_o, 2);
        ticks(2);
        chk("R5", cnt_o, 0);
        ticks(1);
        chk("R5", cnt_o, 1);

        // mixed stimulus, reference compared each clock
        for (int k = 0; k < 8; k++) begin
            wr_cfg(wv_list[k], $urandom % 4, $urandom % 4);
            for (int i = 0; i < 1200; i++) begin
                tick = ($urandom % 4) != 0;
                dir_en = 2'($urandom);
                if ($urandom % 40 == 0) begin
                    cmp_we = 2'($urandom % 3 + 1);
                    case ($urandom % 5)
                        0: v = 0;
                        1: v = 1;
                        2: v = 254;
                        3: v = 255;
                        default: v = $urandom % 256;
                    endcase
                    if (v == 0 && wv_list[k] == 5) v = 1;
                    cmp_wdata = 8'(v);
                end
                cyc();
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule